// File: doc/BRIEF.md
# Transmit and DMA Timeout Monitor

This block watches three things on an Ethernet controller and reports each failure as a one-cycle error pulse for the status register. The first is the length of each outgoing frame, counted in data bytes, to catch babble. The second is the transceiver's heartbeat, a collision indication that must follow the end of every transmission. The third is the DMA memory cycle, which must receive a ready response in time.

A babble pulse only reports the long frame. It does not stop or shorten it. A memory timeout also produces a pulse that switches off both the transmitter and the receiver. The heartbeat window and the memory timeout are fixed in time: 2 us and 25.6 us. The parameter `CLK_MHZ` turns them into cycle counts when the design is elaborated.

Top module: `tx_dma_watchdog`

## Requirements
- R1: Bytes are counted only inside a frame. A frame begins at `tx_frame_start`, and a byte strobe in that same cycle counts as byte 1. The frame lasts until `tx_frame_end`. One cycle after the 1519th counted byte is sampled, `babble_evt` is high for exactly one cycle, and the frame keeps running.
- R2: A frame produces at most one `babble_evt`, however many bytes follow the 1519th.
- R3: No `babble_evt` appears for a frame of 1518 bytes or fewer. None appears for byte strobes seen outside a frame.
- R4: `tx_frame_end` sampled at edge E opens a window of HB = CLK_MHZ*2 cycles. If `col_in` is not sampled high at edges E+1 through E+HB, `hb_err_evt` is high for one cycle after edge E+HB.
- R5: `col_in` sampled high at any edge from E+1 to E+HB closes the window, and no `hb_err_evt` follows.
- R6: `tx_frame_start` sampled during an open heartbeat window cancels it, and no `hb_err_evt` follows.
- R7: `dma_cyc_start` sampled at edge S opens a window of MEM = CLK_MHZ*256/10 cycles. Without `dma_ready` at edges S+1 through S+MEM, `mem_err_evt` is high for one cycle after edge S+MEM. A new start while a window is open restarts the count.
- R8: `dma_ready` sampled at any edge from S+1 to S+MEM closes the window, and no `mem_err_evt` follows.
- R9: `path_off_evt` is high in exactly the cycles in which `mem_err_evt` is high.
- R10: While reset is low, all outputs are 0. Reset also discards any open window and any partial byte count, so no event follows from activity that came before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_frame_start | input | 1 | Strobe: a transmit frame begins |
| tx_frame_end | input | 1 | Strobe: a transmission has ended |
| tx_byte | input | 1 | Strobe: one data byte sent |
| col_in | input | 1 | Collision (heartbeat) input from the transceiver |
| dma_cyc_start | input | 1 | Strobe: a DMA memory cycle begins |
| dma_ready | input | 1 | Ready response for the DMA memory cycle |
| babble_evt | output | 1 | One-cycle babble error pulse |
| hb_err_evt | output | 1 | One-cycle missing-heartbeat error pulse |
| mem_err_evt | output | 1 | One-cycle memory timeout error pulse |
| path_off_evt | output | 1 | One-cycle pulse that switches off the transmitter and receiver |

## Verification
The bench builds the block with `CLK_MHZ` = 5. That gives a 10-cycle heartbeat window and a 128-cycle memory timeout, so the bench can place a response on the last cycle of each window and on the first cycle after it. The babble limit stays at its full value of 1519 bytes. Frames of 1518, 1519 and 1530 bytes therefore test the exact boundary and the single-event rule.

// File: rtl/tdw_pkg.sv
package tdw_pkg;
  // Convert a duration in nanoseconds to whole clock cycles.
  function automatic int ns_to_cycles(input int mhz, input int ns);
    return (mhz * ns) / 1000;
  endfunction

  localparam int HEARTBEAT_NS = 2000;
  localparam int MEM_READY_NS = 25600;
  localparam int BABBLE_BYTES = 1519;
endpackage

// File: rtl/tdw_rst_sync.sv
module tdw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_sync = sync_q;
endmodule

// File: rtl/tdw_byte_limit.sv
module tdw_byte_limit #(
  parameter int LIMIT = 1519
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic end_i,
  input  logic byte_i,
  output logic hit_o
);
  localparam int W = $clog2(LIMIT + 1);

  logic         in_frame_q, in_frame_d;
  logic         done_q, done_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] base;
  logic         base_done;
  logic         counting;
  logic         cnt_en;

  always_comb begin
    in_frame_d = in_frame_q;
    done_d     = done_q;
    cnt_d      = cnt_q;
    hit_o      = 1'b0;
    base       = start_i ? '0 : cnt_q;
    base_done  = start_i ? 1'b0 : done_q;
    counting   = byte_i & (start_i | in_frame_q);
    if (start_i) begin
      in_frame_d = 1'b1;
      done_d     = 1'b0;
      cnt_d      = '0;
    end
    if (counting && !base_done) begin
      cnt_d = base + 1'b1;
      if (base + 1'b1 == W'(LIMIT)) begin
        hit_o  = 1'b1;
        done_d = 1'b1;
      end
    end
    if (end_i && !start_i) in_frame_d = 1'b0;
  end

  assign cnt_en = start_i | counting;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      done_q     <= 1'b0;
      cnt_q      <= '0;
    end else begin
      in_frame_q <= in_frame_d;
      done_q     <= done_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/tdw_window.sv
module tdw_window #(
  parameter int CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic cancel_i,
  input  logic seen_i,
  output logic expire_o
);
  localparam int W = $clog2(CYCLES + 1);

  logic         armed_q, armed_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    armed_d  = armed_q;
    cnt_d    = cnt_q;
    expire_o = 1'b0;
    if (arm_i) begin
      armed_d = 1'b1;
      cnt_d   = W'(CYCLES);
    end else if (armed_q) begin
      if (cancel_i || seen_i) begin
        armed_d = 1'b0;
      end else if (cnt_q == W'(1)) begin
        armed_d  = 1'b0;
        expire_o = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  assign cnt_en = arm_i | armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/tx_dma_watchdog.sv
module tx_dma_watchdog #(
  parameter int CLK_MHZ = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_frame_start,
  input  logic tx_frame_end,
  input  logic tx_byte,
  input  logic col_in,
  input  logic dma_cyc_start,
  input  logic dma_ready,
  output logic babble_evt,
  output logic hb_err_evt,
  output logic mem_err_evt,
  output logic path_off_evt
);
  import tdw_pkg::*;

  localparam int HB_CYC  = ns_to_cycles(CLK_MHZ, HEARTBEAT_NS);
  localparam int MEM_CYC = ns_to_cycles(CLK_MHZ, MEM_READY_NS);

  logic rst_n_s;
  logic babble_hit, hb_expire, mem_expire;
  logic babble_q, hb_q, merr_q, off_q;
  logic babble_d, hb_d, merr_d, off_d;

  tdw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  tdw_byte_limit #(.LIMIT(BABBLE_BYTES)) u_babble (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .start_i (tx_frame_start),
    .end_i   (tx_frame_end),
    .byte_i  (tx_byte),
    .hit_o   (babble_hit)
  );

  tdw_window #(.CYCLES(HB_CYC)) u_heartbeat (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .arm_i    (tx_frame_end & ~tx_frame_start),
    .cancel_i (tx_frame_start),
    .seen_i   (col_in),
    .expire_o (hb_expire)
  );

  tdw_window #(.CYCLES(MEM_CYC)) u_mem_ready (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .arm_i    (dma_cyc_start),
    .cancel_i (1'b0),
    .seen_i   (dma_ready),
    .expire_o (mem_expire)
  );

  always_comb begin
    babble_d = babble_hit;
    hb_d     = hb_expire;
    merr_d   = mem_expire;
    off_d    = mem_expire;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      babble_q <= 1'b0;
      hb_q     <= 1'b0;
      merr_q   <= 1'b0;
      off_q    <= 1'b0;
    end else begin
      babble_q <= babble_d;
      hb_q     <= hb_d;
      merr_q   <= merr_d;
      off_q    <= off_d;
    end
  end

  assign babble_evt   = babble_q;
  assign hb_err_evt   = hb_q;
  assign mem_err_evt  = merr_q;
  assign path_off_evt = off_q;
endmodule

// File: rtl/tdw_chk.sv
module tdw_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_frame_start,
  input logic col_in,
  input logic dma_ready,
  input logic babble_evt,
  input logic hb_err_evt,
  input logic mem_err_evt,
  input logic path_off_evt
);
  // R2
  babble_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    babble_evt |=> !babble_evt);

  // R4
  hb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hb_err_evt |=> !hb_err_evt);

  // R5
  hb_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hb_err_evt |-> !$past(col_in));

  // R6
  hb_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hb_err_evt |-> !$past(tx_frame_start));

  // R8
  mem_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_err_evt |-> !$past(dma_ready));

  // R9
  off_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    path_off_evt == mem_err_evt);
endmodule

bind tx_dma_watchdog tdw_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .tx_frame_start (tx_frame_start),
  .col_in         (col_in),
  .dma_ready      (dma_ready),
  .babble_evt     (babble_evt),
  .hb_err_evt     (hb_err_evt),
  .mem_err_evt    (mem_err_evt),
  .path_off_evt   (path_off_evt)
);

// File: tb/tx_dma_watchdog_tb_top.sv
module tx_dma_watchdog_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MHZ = 5;
  localparam int HB  = MHZ * 2;
  localparam int MEM = MHZ * 256 / 10;
  localparam int LIM = 1519;

  typedef struct {
    int    kind;   // 0 babble, 1 heartbeat, 2 memory, 3 path off
    int    cyc;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_frame_start = 1'b0, tx_frame_end = 1'b0, tx_byte = 1'b0;
  logic col_in = 1'b0, dma_cyc_start = 1'b0, dma_ready = 1'b0;
  logic babble_evt, hb_err_evt, mem_err_evt, path_off_evt;

  int    cyc = 0;
  int    checks = 0;
  int    bad = 0;
  logic  mon_on = 1'b0;
  string phase_req = "R10";
  exp_t  q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tx_dma_watchdog #(.CLK_MHZ(MHZ)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .tx_frame_start(tx_frame_start), .tx_frame_end(tx_frame_end),
    .tx_byte(tx_byte), .col_in(col_in),
    .dma_cyc_start(dma_cyc_start), .dma_ready(dma_ready),
    .babble_evt(babble_evt), .hb_err_evt(hb_err_evt),
    .mem_err_evt(mem_err_evt), .path_off_evt(path_off_evt)
  );

  // Monitor: pop and compare each event the design produces.
  always @(negedge clk) begin
    logic [3:0] ev;
    exp_t e;
    ev = {path_off_evt, mem_err_evt, hb_err_evt, babble_evt};
    if (mon_on) begin
      for (int k = 0; k < 4; k++) begin
        if (ev[k]) begin
          checks++;
          if (q.size() == 0) begin
            bad++;
            $display("FAIL %s: event kind %0d at cycle %0d, expected none", phase_req, k, cyc);
          end else begin
            e = q.pop_front();
            if (e.kind != k || e.cyc != cyc) begin
              bad++;
              $display("FAIL %s: got kind %0d cycle %0d, expected kind %0d cycle %0d",
                       e.req, k, cyc, e.kind, e.cyc);
            end
          end
        end
      end
    end
  end

  task automatic push(input int kind, input int at, input string req);
    exp_t e;
    e.kind = kind; e.cyc = at; e.req = req;
    q.push_back(e);
  endtask

  task automatic drained(input string req);
    checks++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL %s: event kind %0d due at cycle %0d missing, actual none",
               req, q[0].kind, q[0].cyc);
      q.delete();
    end
  endtask

  // Drive one frame; col_at = 0 means no heartbeat at all.
  task automatic frame(input int nbytes, input int col_at, input string req);
    int e;
    phase_req = req;
    for (int i = 1; i <= nbytes; i++) begin
      @(negedge clk);
      tx_frame_start = (i == 1);
      tx_byte = 1'b1;
      if (i == LIM) push(0, cyc + 1, req);
    end
    @(negedge clk);
    tx_byte = 1'b0; tx_frame_start = 1'b0; tx_frame_end = 1'b1;
    e = cyc + 1;
    if (col_at == 0 || col_at > HB) push(1, e + HB, req);
    @(negedge clk);
    tx_frame_end = 1'b0;
    if (col_at > 0) begin
      while (cyc + 1 < e + col_at) @(negedge clk);
      col_in = 1'b1;
      @(negedge clk);
      col_in = 1'b0;
    end
    repeat (HB + 4) @(negedge clk);
    drained(req);
  endtask

  // One DMA cycle; ready_at = 0 means no ready response.
  task automatic dma(input int ready_at, input string req);
    int s;
    phase_req = req;
    @(negedge clk);
    dma_cyc_start = 1'b1;
    s = cyc + 1;
    if (ready_at == 0 || ready_at > MEM) begin
      push(2, s + MEM, req);
      push(3, s + MEM, req);
    end
    @(negedge clk);
    dma_cyc_start = 1'b0;
    if (ready_at > 0) begin
      while (cyc + 1 < s + ready_at) @(negedge clk);
      dma_ready = 1'b1;
      @(negedge clk);
      dma_ready = 1'b0;
    end
    repeat (MEM + 6) @(negedge clk);
    drained(req);
  endtask

  task automatic check_idle(input string req);
    checks++;
    if ({babble_evt, hb_err_evt, mem_err_evt, path_off_evt} !== 4'b0000) begin
      bad++;
      $display("FAIL %s: outputs %b in reset, expected 0000", req,
               {babble_evt, hb_err_evt, mem_err_evt, path_off_evt});
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin : main
    int s2;
    repeat (3) @(negedge clk);
    check_idle("R10");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;

    frame(1530, 3, "R2");       // R1 R2: single babble event, heartbeat in time
    frame(1518, 0, "R3");       // R3 no babble; R4 missing heartbeat
    frame(LIM, HB, "R1");       // R1 exact limit; R5 collision on last window cycle
    frame(20, HB + 1, "R4");    // R4 collision one cycle late

    // R3: byte strobes outside any frame are ignored
    phase_req = "R3";
    @(negedge clk); tx_byte = 1'b1;
    repeat (1600) @(negedge clk);
    tx_byte = 1'b0;
    repeat (5) @(negedge clk);
    drained("R3");

    // R6: frame start inside the heartbeat window cancels it
    phase_req = "R6";
    @(negedge clk); tx_frame_end = 1'b1;
    @(negedge clk); tx_frame_end = 1'b0;
    repeat (3) @(negedge clk);
    tx_frame_start = 1'b1;
    @(negedge clk); tx_frame_start = 1'b0;
    repeat (HB + 6) @(negedge clk);
    drained("R6");
    @(negedge clk); tx_frame_end = 1'b1;
    @(negedge clk); tx_frame_end = 1'b0; col_in = 1'b1;
    @(negedge clk); col_in = 1'b0;
    repeat (HB + 4) @(negedge clk);
    drained("R6");

    dma(0, "R9");               // R7 timeout with R9 path-off pulse
    dma(MEM, "R8");             // R8 ready on the last allowed cycle
    dma(MEM + 1, "R7");         // R7 ready one cycle late

    // R7: second start restarts the count
    phase_req = "R7";
    @(negedge clk); dma_cyc_start = 1'b1;
    @(negedge clk); dma_cyc_start = 1'b0;
    repeat (48) @(negedge clk);
    dma_cyc_start = 1'b1;
    s2 = cyc + 1;
    push(2, s2 + MEM, "R7");
    push(3, s2 + MEM, "R7");
    @(negedge clk); dma_cyc_start = 1'b0;
    repeat (MEM + 6) @(negedge clk);
    drained("R7");

    // R10: reset discards open windows
    @(negedge clk); tx_frame_end = 1'b1; dma_cyc_start = 1'b1;
    @(negedge clk); tx_frame_end = 1'b0; dma_cyc_start = 1'b0;
    repeat (3) @(negedge clk);
    mon_on = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_idle("R10");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    phase_req = "R10";
    mon_on = 1'b1;
    repeat (MEM + 10) @(negedge clk);
    drained("R10");

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule